// File: doc/BRIEF.md
# Bus-Decoded Parallel I/O Ports

This peripheral hangs off a processor bus that has a 16-bit address, separate 8-bit write and read data paths, an I/O-versus-memory qualifier and active-low read and write strobes. It holds three byte-wide ports. The first is a switch input in I/O space. The second is a latched LED output in I/O space, with active-low drive. The third is a switch input in memory space whose partial decode makes it answer at four aliased addresses.

Every access is first qualified by the space select. The I/O-space ports decode only the low address byte. The memory-space port looks at A15 and A12..A0 and ignores A14 and A13. The read path is combinational. When no port is selected it returns zero with its drive flag low. The LED holding register updates on the clock edge at which its write select is active.

Top module: `pio_ports`

## Requirements
- R1: After reset (rst_ni low), led_no is 0xFF, which means all LEDs are off.
- R2: When io_sel_i=1, rd_ni=0 and addr_i[7:0]=0x80, rd_data_o equals sw_io_i and rd_en_o is 1. The upper address byte has no effect on this decode.
- R3: When io_sel_i=1, wr_ni=0 and addr_i[7:0]=0x81, led_no takes the value of wr_data_i on the next rising clock edge.
- R4: led_no holds its value while no write selects the LED port, including after wr_data_i changes.
- R5: When io_sel_i=0 and rd_ni=0, with addr_i[15]=1 and addr_i[12:0]=0, rd_data_o equals sw_mem_i and rd_en_o is 1. This holds at 0x8000, 0xA000, 0xC000 and 0xE000.
- R6: The I/O-space ports ignore memory-space accesses, and the memory-space port ignores I/O-space accesses. In either case the read output stays 0x00 with rd_en_o=0, and led_no does not change.
- R7: Whenever no read select is active, rd_data_o is 0x00 and rd_en_o is 0. This covers reads at addresses that do not decode, such as 0x82 or 0x8001.
- R8: A write to an input-port address leaves led_no unchanged, and so does a read of 0x81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Address bus |
| io_sel_i | input | 1 | 1 selects I/O space, 0 selects memory space |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| wr_data_i | input | 8 | Write data |
| sw_io_i | input | 8 | Switch byte for the I/O-space input port |
| sw_mem_i | input | 8 | Switch byte for the memory-space input port |
| rd_data_o | output | 8 | Read data, 0x00 when not driving |
| rd_en_o | output | 1 | Read drive enable |
| led_no | output | 8 | Latched LED outputs, active low |

## Verification
The assertions assume that rd_ni and wr_ni are never low at the same time, since a real bus cycle is either a read or a write. The assertion that checks one-hot selects depends on this assumption. The stimulus drives at most one strobe low in every vector and every directed step. All inputs change only on the falling clock edge, so each strobe is stable across the rising edge that samples it.

// File: rtl/pio_pkg.sv
package pio_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned DATA_W = 8;
  parameter logic [7:0]  IO_SW_ADDR  = 8'h80;
  parameter logic [7:0]  IO_LED_ADDR = 8'h81;
  typedef struct packed {
    logic io_rd_n;
    logic io_wr_n;
    logic mem_rd_n;
  } strobes_t;
endpackage

// File: rtl/pio_strobe.sv
module pio_strobe (
  input  logic                io_sel_i,
  input  logic                rd_ni,
  input  logic                wr_ni,
  output pio_pkg::strobes_t   stb_o
);
  always_comb begin
    stb_o.io_rd_n  = ~(io_sel_i & ~rd_ni);
    stb_o.io_wr_n  = ~(io_sel_i & ~wr_ni);
    stb_o.mem_rd_n = ~(~io_sel_i & ~rd_ni);
  end
endmodule

// File: rtl/pio_decode.sv
module pio_decode #(
  parameter int unsigned ADDR_W = pio_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  pio_pkg::strobes_t  stb_i,
  output logic               sel_sw_io_o,
  output logic               sel_led_o,
  output logic               sel_sw_mem_o
);
  localparam int unsigned LOW_W = 13;  // A12..A0 must be zero
  logic dev_sw_n, dev_led_n, dev_mem_n;

  always_comb begin
    dev_sw_n  = (addr_i[7:0] != pio_pkg::IO_SW_ADDR);
    dev_led_n = (addr_i[7:0] != pio_pkg::IO_LED_ADDR);
    dev_mem_n = ~(addr_i[ADDR_W-1] && (addr_i[LOW_W-1:0] == '0));
    // select = both active-low terms low
    sel_sw_io_o  = ~(dev_sw_n  | stb_i.io_rd_n);
    sel_led_o    = ~(dev_led_n | stb_i.io_wr_n);
    sel_sw_mem_o = ~(dev_mem_n | stb_i.mem_rd_n);
  end
endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
  parameter int unsigned DATA_W = pio_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '1;
    else if (load_i) q_o <= d_i;
  end

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/pio_ports.sv
module pio_ports #(
  parameter int unsigned ADDR_W = pio_pkg::ADDR_W,
  parameter int unsigned DATA_W = pio_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_sel_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] sw_io_i,
  input  logic [DATA_W-1:0] sw_mem_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_en_o,
  output logic [DATA_W-1:0] led_no
);
  pio_pkg::strobes_t stb;
  logic sel_sw_io, sel_led, sel_sw_mem;

  pio_strobe u_stb (
    .io_sel_i(io_sel_i), .rd_ni(rd_ni), .wr_ni(wr_ni), .stb_o(stb)
  );

  pio_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .stb_i(stb),
    .sel_sw_io_o(sel_sw_io), .sel_led_o(sel_led), .sel_sw_mem_o(sel_sw_mem)
  );

  pio_out_latch #(.DATA_W(DATA_W)) u_led (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sel_led),
    .d_i(wr_data_i), .q_o(led_no)
  );

  always_comb begin
    rd_en_o   = sel_sw_io | sel_sw_mem;
    rd_data_o = '0;
    if (sel_sw_io)       rd_data_o = sw_io_i;
    else if (sel_sw_mem) rd_data_o = sw_mem_i;
  end

  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ni | wr_ni) |-> $onehot0({sel_sw_io, sel_led, sel_sw_mem}));
  a_r6_mem_no_led: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_sel_i |=> $stable(led_no));
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> (!rd_en_o && rd_data_o == '0));
  a_r2_io_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i && !rd_ni && addr_i[7:0] == 8'h80) |-> (rd_en_o && rd_data_o == sw_io_i));
  a_r5_mem_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_sel_i && !rd_ni && addr_i[15] && addr_i[12:0] == '0) |-> (rd_en_o && rd_data_o == sw_mem_i));
  a_r8_rd_led_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(led_no));
endmodule

// File: tb/tb_pio_ports.sv
module tb_pio_ports;
  logic clk = 0, rst_ni = 0;
  logic [15:0] addr = 0;
  logic io_sel = 0, rd_n = 1, wr_n = 1;
  logic [7:0] wdat = 0, sw_io = 8'h5A, sw_mem = 8'hC3;
  logic [7:0] rdat, led;
  logic rd_en;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pio_ports dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .io_sel_i(io_sel),
    .rd_ni(rd_n), .wr_ni(wr_n), .wr_data_i(wdat), .sw_io_i(sw_io),
    .sw_mem_i(sw_mem), .rd_data_o(rdat), .rd_en_o(rd_en), .led_no(led)
  );

  // vector: addr, io_sel, rd_n, exp_en, exp_sel (0 none,1 io,2 mem)
  typedef struct packed {
    logic [15:0] a; logic io; logic rn; logic en; logic [1:0] src;
  } rvec_t;
  localparam int NV = 12;
  localparam rvec_t VEC [NV] = '{
    '{16'h8080, 1'b1, 1'b0, 1'b1, 2'd1},  // R2
    '{16'h0080, 1'b1, 1'b0, 1'b1, 2'd1},  // R2 upper byte ignored
    '{16'h8000, 1'b0, 1'b0, 1'b1, 2'd2},  // R5
    '{16'hA000, 1'b0, 1'b0, 1'b1, 2'd2},  // R5
    '{16'hC000, 1'b0, 1'b0, 1'b1, 2'd2},  // R5
    '{16'hE000, 1'b0, 1'b0, 1'b1, 2'd2},  // R5
    '{16'h8080, 1'b0, 1'b0, 1'b0, 2'd0},  // R6 mem access at io addr
    '{16'h8000, 1'b1, 1'b0, 1'b0, 2'd0},  // R6 io access at mem addr
    '{16'h8282, 1'b1, 1'b0, 1'b0, 2'd0},  // R7
    '{16'h8001, 1'b0, 1'b0, 1'b0, 2'd0},  // R7
    '{16'h9000, 1'b0, 1'b0, 1'b0, 2'd0},  // R7
    '{16'h8080, 1'b1, 1'b1, 1'b0, 2'd0}   // R7 no strobe
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic io, input logic [7:0] d);
    @(negedge clk); addr = a; io_sel = io; wdat = d; wr_n = 0; rd_n = 1;
    @(negedge clk); wr_n = 1; wdat = ~d;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {1'b0, led}, {1'b0, 8'hFF});
    rst_ni = 1;
    @(negedge clk);
    chk("R7 idle", {rd_en, rdat}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr = VEC[i].a; io_sel = VEC[i].io; rd_n = VEC[i].rn; wr_n = 1;
      sw_io = 8'h11 * i[7:0] + 8'h5A; sw_mem = ~sw_io;
      #1;
      chk($sformatf("R2/R5/R6/R7 vec%0d", i), {rd_en, rdat},
          {VEC[i].en, (VEC[i].src == 2'd1) ? sw_io :
                      (VEC[i].src == 2'd2) ? sw_mem : 8'h00});
    end
    @(negedge clk); rd_n = 1;

    wr(16'h8181, 1'b1, 8'hA5);
    chk("R3 write", {1'b0, led}, {1'b0, 8'hA5});
    wr(16'h0081, 1'b1, 8'h3C);
    chk("R3 write low byte", {1'b0, led}, {1'b0, 8'h3C});
    repeat (3) @(negedge clk);
    wdat = 8'h00;
    @(negedge clk);
    chk("R4 hold", {1'b0, led}, {1'b0, 8'h3C});
    wr(16'h0081, 1'b0, 8'h77);
    chk("R6 mem write", {1'b0, led}, {1'b0, 8'h3C});
    wr(16'h8080, 1'b1, 8'h77);
    chk("R8 write io input", {1'b0, led}, {1'b0, 8'h3C});
    wr(16'h8000, 1'b0, 8'h77);
    chk("R8 write mem input", {1'b0, led}, {1'b0, 8'h3C});
    @(negedge clk); addr = 16'h8181; io_sel = 1; rd_n = 0; wdat = 8'h99;
    #1;
    chk("R8 read led addr", {rd_en, rdat}, 9'h000);
    @(negedge clk); rd_n = 1;
    @(negedge clk);
    chk("R8 read led no change", {1'b0, led}, {1'b0, 8'h3C});

    rst_ni = 0;
    @(negedge clk);
    chk("R1 re-reset", {1'b0, led}, {1'b0, 8'hFF});
    rst_ni = 1;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule